// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block is an iterative unsigned multiplier and divider for an accumulator-style datapath. A single-cycle start pulse hands it an operation, an operand size, the current accumulator, the current high-word register and a source operand. It then retires one operand bit per clock: shift-and-add for a product, restoring shift-and-subtract for a quotient. The result lands in fixed places. A byte product fills the whole accumulator. A word product is split between the high-word register and the accumulator. A byte quotient and remainder share the accumulator's two halves. A word quotient and remainder go to the accumulator and the high-word register.

After a multiply the carry and overflow outputs together report whether the upper half of the product holds anything. A divide leaves both flags untouched. A divide whose divisor is zero, or whose quotient would not fit the selected width, is refused at once. The block flags the error, alongside the done pulse, and keeps its previous results. The surrounding pipeline waits for the done pulse and copies the result outputs into its register file.

The controller moves through four named states. IDLE waits for start. On start it goes to FAULT if the divide precheck fails and to RUN otherwise. RUN performs one iteration per cycle and goes to PACK after the last one. PACK commits the packed result and returns to IDLE. FAULT reports the refusal and returns to IDLE.

Top module: `seq_muldiv`

## Requirements
- R1: Byte multiply (op_div=0, size_word=0): acc_out becomes acc_in[7:0] * src_in[7:0] as 16 bits, and hi_out becomes the hi_in value captured at start.
- R2: Word multiply (op_div=0, size_word=1): hi_out becomes bits 31:16 and acc_out bits 15:0 of acc_in * src_in.
- R3: After a multiply, cf and of are both 1 when the upper half of the product (acc_out[15:8] for byte, hi_out for word) is nonzero, and both 0 otherwise.
- R4: Byte divide (op_div=1, size_word=0): the 16-bit acc_in is divided by src_in[7:0]; acc_out[7:0] becomes the quotient, acc_out[15:8] the remainder, and hi_out the captured hi_in.
- R5: Word divide (op_div=1, size_word=1): the dividend is {hi_in, acc_in}; acc_out becomes the quotient and hi_out the remainder.
- R6: A divide leaves cf and of at the values they held before it.
- R7: A divide with a zero divisor or a quotient above the width's maximum (255 byte, 65535 word) raises div_err together with done, and leaves acc_out, hi_out, cf and of unchanged.
- R8: done is high for exactly one cycle. For an accepted operation it rises N+1 rising edges after the edge that samples start (N=8 byte, N=16 word). For a refused divide it rises on the following edge.
- R9: busy is high from the edge after start is accepted until done rises. A start pulse while busy is ignored, and the operands captured at acceptance are the ones used.
- R10: During reset and until the first result, acc_out, hi_out, cf, of, done, div_err and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| size_word | input | 1 | 0 = byte operands, 1 = word operands |
| acc_in | input | 16 | Accumulator value at start |
| hi_in | input | 16 | High-word register value at start |
| src_in | input | 16 | Source operand (low byte used in byte mode) |
| acc_out | output | 16 | Accumulator result |
| hi_out | output | 16 | High-word register result |
| done | output | 1 | One-cycle completion pulse |
| cf | output | 1 | Carry flag value |
| of | output | 1 | Overflow flag value |
| div_err | output | 1 | Divide refused, valid with done |
| busy | output | 1 | Operation in progress |

## Verification
The sweeps cross corner operands (zero, one, all-ones, top bit only) with spread values in all four operation modes. The divide boundary is hit on both sides. A high part one below the divisor gives the largest legal quotient. A high part equal to the divisor, or a zero divisor, must be refused. A design that checks only for zero would return a truncated quotient there, and one that writes on error would clobber the accumulator. A byte multiply whose product leaves the upper byte empty, run straight after one that filled it, catches flags that stick or that test the wrong half. A divide after a flag-setting multiply exposes a unit that clears flags on divide. A second start pulse with scrambled operands in the middle of a run catches a controller that restarts or re-samples while busy.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PACK  = 2'd2,
        ST_FAULT = 2'd3
    } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic size_word,
    input  logic fault_in,
    output logic load,
    output logic step,
    output logic commit,
    output logic fault,
    output logic busy
);
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    md_state_e        state, state_nx;
    logic [CNT_W-1:0] iter_cnt;
    logic [CNT_W-1:0] iter_lim;
    logic             last_iter;

    assign last_iter = (iter_cnt == iter_lim - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_cnt <= '0;
            iter_lim <= '0;
        end else if (state == ST_IDLE && start) begin
            iter_cnt <= '0;
            iter_lim <= size_word ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
        end else if (state == ST_RUN) begin
            iter_cnt <= iter_cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = fault_in ? ST_FAULT : ST_RUN;
            ST_RUN:   if (last_iter) state_nx = ST_PACK;
            ST_PACK:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        commit = 1'b0;
        fault  = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start && !fault_in;
            end
            ST_RUN:   step   = 1'b1;
            ST_PACK:  commit = 1'b1;
            ST_FAULT: fault  = 1'b1;
        endcase
    end
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod
);
    logic [W-1:0] upper_q, lower_q, mcand_q;
    logic [W:0]   partial;

    assign partial = {1'b0, upper_q} + (lower_q[0] ? {1'b0, mcand_q} : '0);

    always_ff @(posedge clk) begin
        if (load) begin
            upper_q <= '0;
            lower_q <= mplier;
            mcand_q <= mcand;
        end else if (step) begin
            upper_q <= partial[W:1];
            lower_q <= {partial[0], lower_q[W-1:1]};
        end
    end

    assign prod = {upper_q, lower_q};
endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] rem_init,
    input  logic [W-1:0] quo_init,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] rem,
    output logic [W-1:0] quo
);
    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic [W:0]   trial, diff;

    assign trial = {rem_q, quo_q[W-1]};
    assign diff  = trial - {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q <= rem_init;
            quo_q <= quo_init;
            dvs_q <= divisor;
        end else if (step) begin
            if (!diff[W]) begin
                rem_q <= diff[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign rem = rem_q;
    assign quo = quo_q;
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_div,
    input  logic              size_word,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] hi_in,
    input  logic [WORD_W-1:0] src_in,
    output logic [WORD_W-1:0] acc_out,
    output logic [WORD_W-1:0] hi_out,
    output logic              done,
    output logic              cf,
    output logic              of,
    output logic              div_err,
    output logic              busy
);
    localparam int HALF_W = WORD_W / 2;

    logic load, step, commit, fault, fault_in;
    logic op_q, size_q;
    logic [WORD_W-1:0]   hi_q;
    logic [WORD_W-1:0]   dvs_ext, dvd_hi, quo_init;
    logic [WORD_W-1:0]   mcand_ext, mplier_ext;
    logic [2*WORD_W-1:0] prod;
    logic [WORD_W-1:0]   rem, quo;
    logic [WORD_W-1:0]   byte_prod;
    logic [WORD_W-1:0]   pack_acc, pack_hi;
    logic                pack_flag;

    // operand alignment for the two sizes
    always_comb begin
        if (size_word) begin
            dvs_ext    = src_in;
            dvd_hi     = hi_in;
            quo_init   = acc_in;
            mcand_ext  = acc_in;
            mplier_ext = src_in;
        end else begin
            dvs_ext    = {{HALF_W{1'b0}}, src_in[HALF_W-1:0]};
            dvd_hi     = {{HALF_W{1'b0}}, acc_in[WORD_W-1:HALF_W]};
            quo_init   = {acc_in[HALF_W-1:0], {HALF_W{1'b0}}};
            mcand_ext  = {{HALF_W{1'b0}}, acc_in[HALF_W-1:0]};
            mplier_ext = {{HALF_W{1'b0}}, src_in[HALF_W-1:0]};
        end
    end

    // high part not below divisor: zero divisor or quotient overflow
    assign fault_in = op_div && (dvd_hi >= dvs_ext);

    muldiv_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .size_word (size_word),
        .fault_in  (fault_in),
        .load      (load),
        .step      (step),
        .commit    (commit),
        .fault     (fault),
        .busy      (busy)
    );

    mul_shift_add #(.W(WORD_W)) u_mul (
        .clk    (clk),
        .load   (load && !op_div),
        .step   (step && !op_q),
        .mcand  (mcand_ext),
        .mplier (mplier_ext),
        .prod   (prod)
    );

    div_restoring #(.W(WORD_W)) u_div (
        .clk      (clk),
        .load     (load && op_div),
        .step     (step && op_q),
        .rem_init (dvd_hi),
        .quo_init (quo_init),
        .divisor  (dvs_ext),
        .rem      (rem),
        .quo      (quo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= 1'b0;
            size_q <= 1'b0;
            hi_q   <= '0;
        end else if (load) begin
            op_q   <= op_div;
            size_q <= size_word;
            hi_q   <= hi_in;
        end
    end

    // after a byte run the product sits HALF_W places up
    assign byte_prod = prod[WORD_W+HALF_W-1:HALF_W];

    always_comb begin
        unique case ({op_q, size_q})
            2'b00: begin
                pack_acc  = byte_prod;
                pack_hi   = hi_q;
                pack_flag = |byte_prod[WORD_W-1:HALF_W];
            end
            2'b01: begin
                pack_acc  = prod[WORD_W-1:0];
                pack_hi   = prod[2*WORD_W-1:WORD_W];
                pack_flag = |prod[2*WORD_W-1:WORD_W];
            end
            2'b10: begin
                pack_acc  = {rem[HALF_W-1:0], quo[HALF_W-1:0]};
                pack_hi   = hi_q;
                pack_flag = 1'b0;
            end
            2'b11: begin
                pack_acc  = quo;
                pack_hi   = rem;
                pack_flag = 1'b0;
            end
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out <= '0;
            hi_out  <= '0;
            cf      <= 1'b0;
            of      <= 1'b0;
            done    <= 1'b0;
            div_err <= 1'b0;
        end else begin
            done    <= commit || fault;
            div_err <= fault;
            if (commit) begin
                acc_out <= pack_acc;
                hi_out  <= pack_hi;
                if (!op_q) begin
                    cf <= pack_flag;
                    of <= pack_flag;
                end
            end
        end
    end
endmodule

// File: rtl/seq_muldiv_chk.sv
module seq_muldiv_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              div_err,
    input logic              cf,
    input logic              of,
    input logic [WORD_W-1:0] acc_out,
    input logic [WORD_W-1:0] hi_out,
    input logic              op_q,
    input logic              size_q
);
    localparam int HALF_W = WORD_W / 2;

    a_r3_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q) |-> (cf == of));

    a_r3_word_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q && size_q) |-> (cf == (hi_out != '0)));

    a_r3_byte_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_q && !size_q) |-> (cf == (acc_out[WORD_W-1:HALF_W] != '0)));

    a_r6_div_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q) |-> ($stable(cf) && $stable(of)));

    a_r7_err_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (done && $stable(acc_out) && $stable(hi_out)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind seq_muldiv seq_muldiv_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .div_err (div_err),
    .cf      (cf),
    .of      (of),
    .acc_out (acc_out),
    .hi_out  (hi_out),
    .op_q    (op_q),
    .size_q  (size_q)
);

// File: tb/seq_muldiv_test.sv
module seq_muldiv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        size_word = 1'b0;
    logic [15:0] acc_in = '0, hi_in = '0, src_in = '0;
    logic [15:0] acc_out, hi_out;
    logic        done, cf, of, div_err, busy;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_acc = '0, m_hi = '0;
    logic        m_cf = 1'b0;

    always #2 clk = ~clk;

    seq_muldiv uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .size_word(size_word), .acc_in(acc_in), .hi_in(hi_in), .src_in(src_in),
        .acc_out(acc_out), .hi_out(hi_out), .done(done), .cf(cf), .of(of),
        .div_err(div_err), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] v16(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h8000;
            4: return 16'h00FF;
            5: return 16'h7FFF;
            default: return 16'((i * 40503 + 12345) & 16'hFFFF);
        endcase
    endfunction

    function automatic logic [7:0] v8(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'hFF;
            3: return 8'h80;
            4: return 8'h7F;
            default: return 8'((i * 73 + 11) & 8'hFF);
        endcase
    endfunction

    task automatic run_op(input logic dv, input logic wd, input logic [15:0] a,
                          input logic [15:0] h, input logic [15:0] s, input logic poke);
        int c;
        logic [31:0] p, dd;
        logic [15:0] e_acc, e_hi, s8;
        logic e_flag, e_err;
        int e_lat;
        string t_res, t_flag;
        @(negedge clk);
        op_div = dv; size_word = wd; acc_in = a; hi_in = h; src_in = s; start = 1'b1;
        @(negedge clk);
        c = 1;
        start = 1'b0;
        if (poke) begin
            chk("R9 busy after accept", 32'(busy), 32'd1);
            start = 1'b1; acc_in = ~a; hi_in = ~h; src_in = s ^ 16'h5A5A;
            op_div = ~dv;
        end
        while (!done && c < 60) begin
            @(negedge clk);
            c++;
            start = 1'b0;
        end
        // expected values from the arithmetic
        e_err = 1'b0; e_flag = m_cf; e_acc = m_acc; e_hi = m_hi;
        s8 = {8'h00, s[7:0]};
        if (!dv) begin
            t_res = wd ? "R2 word multiply" : "R1 byte multiply";
            t_flag = "R3 multiply flags";
            if (wd) begin
                p = 32'(a) * 32'(s);
                e_acc = p[15:0]; e_hi = p[31:16]; e_flag = |p[31:16];
            end else begin
                p = 32'(a[7:0]) * 32'(s[7:0]);
                e_acc = p[15:0]; e_hi = h; e_flag = |p[15:8];
            end
        end else begin
            t_res = wd ? "R5 word divide" : "R4 byte divide";
            t_flag = "R6 divide keeps flags";
            if (wd) begin
                dd = {h, a};
                if (s == 0 || dd / 32'(s) > 32'hFFFF) e_err = 1'b1;
                else begin
                    e_acc = 16'(dd / 32'(s)); e_hi = 16'(dd % 32'(s));
                end
            end else begin
                if (s8 == 0 || a / s8 > 16'h00FF) e_err = 1'b1;
                else begin
                    e_acc = {8'(a % s8), 8'(a / s8)}; e_hi = h;
                end
            end
        end
        if (e_err) begin
            t_res = "R7 refused keeps result";
            t_flag = "R7 refused keeps flags";
        end
        e_lat = e_err ? 2 : (wd ? 18 : 10);
        chk("R8 done latency", 32'(c), 32'(e_lat));
        chk("R7 div_err", 32'(div_err), 32'(e_err));
        chk(t_res, {hi_out, acc_out}, {e_hi, e_acc});
        chk(t_flag, {30'd0, cf, of}, {30'd0, e_flag, e_flag});
        m_acc = e_acc; m_hi = e_hi; m_cf = e_flag;
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {hi_out, acc_out}, 32'd0);
        chk("R10 reset flags", {27'd0, done, cf, of, div_err, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {27'd0, done, cf, of, div_err, busy}, 32'd0);

        // directed corners
        run_op(1'b0, 1'b0, 16'h12FF, 16'hBEEF, 16'h00FF, 1'b0); // flags set, R1/R3
        run_op(1'b1, 1'b0, 16'h0064, 16'hBEEF, 16'h0007, 1'b0); // R6 flags stay set
        run_op(1'b0, 1'b0, 16'h0010, 16'h1234, 16'h000F, 1'b0); // R3 flags clear
        run_op(1'b1, 1'b1, 16'hFFFF, 16'h1233, 16'h1234, 1'b0); // R5 max quotient
        run_op(1'b1, 1'b1, 16'h0000, 16'h1234, 16'h1234, 1'b0); // R7 overflow
        run_op(1'b1, 1'b0, 16'h1234, 16'h0000, 16'h0000, 1'b0); // R7 zero divisor
        run_op(1'b1, 1'b0, 16'h12FF, 16'h0000, 16'h0013, 1'b0); // R4 max quotient
        run_op(1'b1, 1'b0, 16'h1300, 16'h0000, 16'h0013, 1'b0); // R7 byte overflow
        run_op(1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b1); // R9 poke while busy
        run_op(1'b1, 1'b1, 16'h5678, 16'h0001, 16'h0300, 1'b1); // R9 poke divide

        // sweeps
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                run_op(1'b0, 1'b0, {v8(j + 7), v8(i)}, v16(i + j), {v8(i + 3), v8(j)}, 1'b0);
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                run_op(1'b1, 1'b0, v16(i) >> (i % 9), v16(j), {8'h00, v8(j)}, 1'b0);
        for (int i = 0; i < 20; i++)
            for (int j = 0; j < 20; j++)
                run_op(1'b0, 1'b1, v16(i), v16(j + 1), v16(j), 1'b0);
        for (int i = 0; i < 20; i++)
            for (int j = 0; j < 20; j++)
                run_op(1'b1, 1'b1, v16(i + 2), v16(i) >> (j % 17), v16(j), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule